// File: doc/BRIEF.md
# PLL Power-Up and Lock Sequencer

This block runs the ordered bring-up and tear-down of a clock-generating PLL and the clocks that depend on it. On a start request it turns on the bias of the master channel and, when a second channel is built in, the slave bias. Each bias gets a settle wait. The block then sets the PLL run bit and waits for lock. Once lock is seen it pulses the digital reset of each channel and opens the output clock gates, master first.

Lock is sampled only once per poll interval, and the interval is measured with an external microsecond tick. If no lock has been seen when the timeout budget ends, the block raises an error and stops there. A stop request runs the reverse order: gate the clock, drop the run bit, remove bias and wait for it to settle, then repeat the gating and bias removal for the slave. The analog PLL is outside this block. The block only drives its control strobes.

Top module: `pll_pwr_seq`

## Requirements
- R1: After reset every output is low.
- R2: Power-up raises master bias first. The slave bias rises exactly SETTLE cycles later, where SETTLE = ceil(SETTLE_NS x CLK_MHZ / 1000). The PLL run bit rises at least SETTLE cycles after the last bias rise.
- R3: Lock is sampled only on a microsecond tick that completes a whole poll interval, counted from the rise of the run bit. Lock is accepted on the first tick number that is a multiple of POLL_US and is no earlier than the tick where lock went high. A lock level present only between sample points is ignored.
- R4: If no lock is sampled by tick TIMEOUT_US, error rises and the sequence halts with no digital reset and no clock enable. Lock seen on the sample at tick TIMEOUT_US itself is still accepted.
- R5: After lock, the master digital reset is high for exactly one cycle. The slave reset pulse follows it. Both pulses end before any clock enable.
- R6: The master clock enable rises before the slave clock enable, and done pulses when the power-up completes.
- R7: pll_on rises on lock acceptance and falls when power-down begins, before any clock gate closes. It is never high together with error.
- R8: Power-down closes the master clock gate, then clears the run bit, then drops master bias. After at least SETTLE cycles it closes the slave clock gate and then drops slave bias. It waits SETTLE cycles more and pulses done.
- R9: A stop request while waiting for lock abandons power-up and runs the power-down. No reset pulse, clock enable or pll_on occurs, and error stays low.
- R10: With HAS_SLAVE = 0 the slave outputs stay low and the slave steps are skipped.
- R11: error stays high through a power-down from the failed state and is cleared by the next accepted start request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Begin power-up (accepted when idle) |
| stop_req | input | 1 | Begin power-down (accepted while waiting for lock, running, or failed) |
| lock_in | input | 1 | Lock status from the PLL |
| us_tick | input | 1 | One-cycle strobe per microsecond |
| m_bias_en | output | 1 | Master channel bias enable |
| m_dig_rst | output | 1 | Master channel digital reset |
| m_clk_en | output | 1 | Master channel output clock gate |
| s_bias_en | output | 1 | Slave channel bias enable |
| s_dig_rst | output | 1 | Slave channel digital reset |
| s_clk_en | output | 1 | Slave channel output clock gate |
| pll_start | output | 1 | PLL run bit |
| pll_on | output | 1 | PLL locked and in service |
| done | output | 1 | One-cycle pulse when a power-up or power-down completes |
| error | output | 1 | Lock timeout flag |

## Verification
The lock wait is driven with lock arriving at different tick counts. Arrivals right after the run bit, in the middle of a poll interval, exactly on the final sample and one tick after it separate early acceptance, rounding up to the next sample, the boundary case and the timeout. A lock level that appears only on an off-sample tick shows that lock is read only at the interval. A stop raised during the wait shows the abort path. For each run, the cycle stamps of every strobe edge are compared to the required order and settle gaps, and a second instance without the slave shows the slave steps are skipped.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;

  typedef enum logic [4:0] {
    ST_IDLE, ST_MBIAS, ST_SBIAS, ST_GO, ST_LOCK,
    ST_MRST, ST_SRST, ST_MCLK, ST_SCLK, ST_ON, ST_FAIL,
    ST_D_MGATE, ST_D_PLL, ST_D_MOFF, ST_D_MWAIT,
    ST_D_SGATE, ST_D_SOFF, ST_D_SWAIT
  } seq_st_e;

  // per-channel set/clear commands issued by the sequencer
  typedef struct packed {
    logic bias_on;
    logic bias_off;
    logic rst_set;
    logic rst_clr;
    logic clk_on;
    logic clk_off;
  } chan_cmd_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // bits needed to hold values 0..n
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/pps_settle.sv
`timescale 1ns/1ps
module pps_settle #(
  parameter int CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);
  localparam int LEN = (CYC < 1) ? 1 : CYC;
  localparam int W   = pps_pkg::cnt_w(LEN);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= W'(LEN);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  // last cycle of the wait: the next edge leaves the wait state
  assign expire = (cnt == W'(1));
endmodule

// File: rtl/pps_lock_poll.sv
`timescale 1ns/1ps
module pps_lock_poll #(
  parameter int POLL_US    = 100,
  parameter int TIMEOUT_US = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic tick,
  input  logic lock,
  output logic locked,
  output logic timeout
);
  localparam int PW = pps_pkg::cnt_w(POLL_US);
  localparam int TW = pps_pkg::cnt_w(TIMEOUT_US);

  logic [PW-1:0] phase;
  logic [TW-1:0] total;
  logic          sample;

  assign sample  = en && tick && (phase == PW'(POLL_US - 1));
  assign locked  = sample && lock;
  assign timeout = en && tick && (total == TW'(TIMEOUT_US - 1)) && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      total <= '0;
    end else if (clr) begin
      phase <= '0;
      total <= '0;
    end else if (en && tick) begin
      phase <= (phase == PW'(POLL_US - 1)) ? '0 : phase + 1'b1;
      if (total != TW'(TIMEOUT_US)) total <= total + 1'b1;
    end
  end
endmodule

// File: rtl/pps_chan.sv
`timescale 1ns/1ps
module pps_chan (
  input  logic                clk,
  input  logic                rst_n,
  input  pps_pkg::chan_cmd_t  cmd,
  output logic                bias_en,
  output logic                dig_rst,
  output logic                clk_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bias_en <= 1'b0;
      dig_rst <= 1'b0;
      clk_en  <= 1'b0;
    end else begin
      if (cmd.bias_on)       bias_en <= 1'b1;
      else if (cmd.bias_off) bias_en <= 1'b0;
      if (cmd.rst_set)       dig_rst <= 1'b1;
      else if (cmd.rst_clr)  dig_rst <= 1'b0;
      if (cmd.clk_on)        clk_en  <= 1'b1;
      else if (cmd.clk_off)  clk_en  <= 1'b0;
    end
  end

  // R5
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dig_rst) |=> !dig_rst);

  // R6
  clk_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> (bias_en && !dig_rst));

  // R8
  bias_off_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bias_en) |-> !clk_en);
endmodule

// File: rtl/pll_pwr_seq.sv
`timescale 1ns/1ps
module pll_pwr_seq #(
  parameter int HAS_SLAVE  = 1,
  parameter int CLK_MHZ    = 125,
  parameter int SETTLE_NS  = 250,
  parameter int POLL_US    = 100,
  parameter int TIMEOUT_US = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic stop_req,
  input  logic lock_in,
  input  logic us_tick,
  output logic m_bias_en,
  output logic m_dig_rst,
  output logic m_clk_en,
  output logic s_bias_en,
  output logic s_dig_rst,
  output logic s_clk_en,
  output logic pll_start,
  output logic pll_on,
  output logic done,
  output logic error
);
  import pps_pkg::*;

  localparam int SETTLE_CYC = ceil_div(SETTLE_NS * CLK_MHZ, 1000);
  localparam bit SLV        = (HAS_SLAVE != 0);

  seq_st_e   st, nxt;
  chan_cmd_t mcmd, scmd;
  logic settle_ld, settle_exp, poll_clr, lock_ok, lock_tmo;
  logic set_start, clr_start, set_on, clr_on, set_err, clr_err, fin;

  pps_settle #(.CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .load(settle_ld), .expire(settle_exp));

  pps_lock_poll #(.POLL_US(POLL_US), .TIMEOUT_US(TIMEOUT_US)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .en(st == ST_LOCK),
    .tick(us_tick), .lock(lock_in), .locked(lock_ok), .timeout(lock_tmo));

  always_comb begin
    nxt = st;
    mcmd = '0; scmd = '0;
    settle_ld = 1'b0; poll_clr = 1'b0;
    set_start = 1'b0; clr_start = 1'b0;
    set_on = 1'b0; clr_on = 1'b0;
    set_err = 1'b0; clr_err = 1'b0;
    fin = 1'b0;
    unique case (st)
      ST_IDLE: if (start_req) begin
        mcmd.bias_on = 1'b1; settle_ld = 1'b1; clr_err = 1'b1; nxt = ST_MBIAS;
      end
      ST_MBIAS: if (settle_exp) begin
        if (SLV) begin scmd.bias_on = 1'b1; settle_ld = 1'b1; nxt = ST_SBIAS; end
        else nxt = ST_GO;
      end
      ST_SBIAS: if (settle_exp) nxt = ST_GO;
      ST_GO: begin set_start = 1'b1; poll_clr = 1'b1; nxt = ST_LOCK; end
      ST_LOCK: begin
        if (stop_req) nxt = ST_D_MGATE;
        else if (lock_ok) begin set_on = 1'b1; mcmd.rst_set = 1'b1; nxt = ST_MRST; end
        else if (lock_tmo) begin set_err = 1'b1; nxt = ST_FAIL; end
      end
      ST_MRST: begin
        mcmd.rst_clr = 1'b1;
        if (SLV) begin scmd.rst_set = 1'b1; nxt = ST_SRST; end
        else nxt = ST_MCLK;
      end
      ST_SRST: begin scmd.rst_clr = 1'b1; nxt = ST_MCLK; end
      ST_MCLK: begin
        mcmd.clk_on = 1'b1;
        if (SLV) nxt = ST_SCLK;
        else begin fin = 1'b1; nxt = ST_ON; end
      end
      ST_SCLK: begin scmd.clk_on = 1'b1; fin = 1'b1; nxt = ST_ON; end
      ST_ON: if (stop_req) begin clr_on = 1'b1; nxt = ST_D_MGATE; end
      ST_FAIL: if (stop_req) nxt = ST_D_MGATE;
      ST_D_MGATE: begin mcmd.clk_off = 1'b1; nxt = ST_D_PLL; end
      ST_D_PLL: begin clr_start = 1'b1; nxt = ST_D_MOFF; end
      ST_D_MOFF: begin mcmd.bias_off = 1'b1; settle_ld = 1'b1; nxt = ST_D_MWAIT; end
      ST_D_MWAIT: if (settle_exp) begin
        if (SLV) nxt = ST_D_SGATE;
        else begin fin = 1'b1; nxt = ST_IDLE; end
      end
      ST_D_SGATE: begin scmd.clk_off = 1'b1; nxt = ST_D_SOFF; end
      ST_D_SOFF: begin scmd.bias_off = 1'b1; settle_ld = 1'b1; nxt = ST_D_SWAIT; end
      ST_D_SWAIT: if (settle_exp) begin fin = 1'b1; nxt = ST_IDLE; end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pll_start <= 1'b0;
      pll_on    <= 1'b0;
      error     <= 1'b0;
      done      <= 1'b0;
    end else begin
      st   <= nxt;
      done <= fin;
      if (set_start)      pll_start <= 1'b1;
      else if (clr_start) pll_start <= 1'b0;
      if (set_on)         pll_on <= 1'b1;
      else if (clr_on)    pll_on <= 1'b0;
      if (set_err)        error <= 1'b1;
      else if (clr_err)   error <= 1'b0;
    end
  end

  pps_chan u_mchan (.clk(clk), .rst_n(rst_n), .cmd(mcmd),
    .bias_en(m_bias_en), .dig_rst(m_dig_rst), .clk_en(m_clk_en));

  generate
    if (HAS_SLAVE != 0) begin : g_slave
      pps_chan u_schan (.clk(clk), .rst_n(rst_n), .cmd(scmd),
        .bias_en(s_bias_en), .dig_rst(s_dig_rst), .clk_en(s_clk_en));
    end else begin : g_noslave
      assign s_bias_en = 1'b0;
      assign s_dig_rst = 1'b0;
      assign s_clk_en  = 1'b0;
    end
  endgenerate

  // R2
  start_after_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_start) |-> (m_bias_en && (HAS_SLAVE == 0 || s_bias_en)));

  // R3
  lock_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_on) |-> ($past(us_tick) && $past(lock_in)));

  // R4
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!m_clk_en && !m_dig_rst));

  // R7
  on_needs_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_on |-> (pll_start && !error));

  // R8
  pll_off_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_start) |-> !m_clk_en);
endmodule

// File: tb/sim_pll_pwr_seq.sv
`timescale 1ns/1ps
module sim_pll_pwr_seq;
  localparam int P_POLL = 4;
  localparam int P_TOUT = 16;
  localparam int P_SNS  = 24;
  localparam int P_MHZ  = 125;
  localparam int SET    = (P_SNS * P_MHZ + 999) / 1000;  // 3 cycles
  localparam int NEVER  = 1000;

  // lock_at, glitch_at, stop_at, expect_error, expect_on
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{1,     0, 0, 0, 1},
    '{9,     0, 0, 0, 1},
    '{16,    0, 0, 0, 1},
    '{17,    0, 0, 1, 0},
    '{NEVER, 6, 0, 1, 0},
    '{NEVER, 0, 5, 0, 0},
    '{4,     0, 0, 0, 1}
  };

  localparam int I_MB = 0, I_SB = 1, I_PS = 2, I_MR = 3, I_SR = 4, I_MC = 5, I_SC = 6, I_ON = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_t = 1'b0, stop_t = 1'b0, stop_a = 1'b0, tick = 1'b0, lock = 1'b0;
  wire  stop_req = stop_t | stop_a;
  wire  m_bias_en, m_dig_rst, m_clk_en, s_bias_en, s_dig_rst, s_clk_en;
  wire  pll_start, pll_on, done, error;
  wire  u1_mb, u1_mr, u1_mc, u1_sb, u1_sr, u1_sc, u1_ps, u1_on, u1_done, u1_err;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int lock_at = NEVER, glitch_at = 0, stop_at = 0, tcnt = 0, on_tcnt = -1;
  int tr [8];
  int tf [8];
  logic [7:0] prev = '0;
  bit u1_s_seen = 1'b0;

  always #4 clk = ~clk;

  pll_pwr_seq #(.HAS_SLAVE(1), .CLK_MHZ(P_MHZ), .SETTLE_NS(P_SNS),
                .POLL_US(P_POLL), .TIMEOUT_US(P_TOUT)) u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start_t), .stop_req(stop_req),
    .lock_in(lock), .us_tick(tick),
    .m_bias_en(m_bias_en), .m_dig_rst(m_dig_rst), .m_clk_en(m_clk_en),
    .s_bias_en(s_bias_en), .s_dig_rst(s_dig_rst), .s_clk_en(s_clk_en),
    .pll_start(pll_start), .pll_on(pll_on), .done(done), .error(error));

  pll_pwr_seq #(.HAS_SLAVE(0), .CLK_MHZ(P_MHZ), .SETTLE_NS(P_SNS),
                .POLL_US(P_POLL), .TIMEOUT_US(P_TOUT)) u1 (
    .clk(clk), .rst_n(rst_n), .start_req(start_t), .stop_req(stop_req),
    .lock_in(1'b1), .us_tick(tick),
    .m_bias_en(u1_mb), .m_dig_rst(u1_mr), .m_clk_en(u1_mc),
    .s_bias_en(u1_sb), .s_dig_rst(u1_sr), .s_clk_en(u1_sc),
    .pll_start(u1_ps), .pll_on(u1_on), .done(u1_done), .error(u1_err));

  wire [7:0] watch = {pll_on, s_clk_en, m_clk_en, s_dig_rst, m_dig_rst,
                      pll_start, s_bias_en, m_bias_en};

  always @(posedge clk) cyc <= cyc + 1;

  // edge stamps, microsecond tick, lock model and stop-at-tick strobe
  always @(negedge clk) begin
    for (int k = 0; k < 8; k++) begin
      if (watch[k] && !prev[k] && tr[k] < 0) tr[k] = cyc;
      if (!watch[k] && prev[k] && tf[k] < 0) tf[k] = cyc;
    end
    if (watch[I_ON] && !prev[I_ON]) on_tcnt = tcnt;
    prev = watch;
    if (u1_sb || u1_sr || u1_sc) u1_s_seen = 1'b1;
    stop_a = 1'b0;
    tick = ~tick;
    if (!pll_start) begin
      tcnt = 0;
      lock = 1'b0;
    end else if (tick) begin
      tcnt++;
      lock = (tcnt >= lock_at) || (tcnt == glitch_at);
      if (tcnt == stop_at) stop_a = 1'b1;
    end else begin
      lock = (tcnt >= lock_at);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_stamps();
    for (int k = 0; k < 8; k++) begin tr[k] = -1; tf[k] = -1; end
    on_tcnt = -1;
  endtask

  task automatic wait_done(input string req);
    bit seen = 1'b0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
    chk(seen, req, "done pulse seen", seen, 1);
    @(negedge clk);
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_t = 1'b1;
    @(negedge clk); stop_t = 1'b0;
  endtask

  task automatic run_vec(input int i);
    bit was_err = error;
    bit seen = 1'b0;
    int exp_tick;
    lock_at = VEC[i][0]; glitch_at = VEC[i][1]; stop_at = VEC[i][2];
    clear_stamps();
    @(negedge clk); start_t = 1'b1;
    @(negedge clk); start_t = 1'b0;
    if (was_err) chk(error == 1'b0, "R11", "error cleared by start", error, 0);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (done || error) begin seen = 1'b1; break; end
    end
    chk(seen, "R6", "sequence reached an end", seen, 1);
    @(negedge clk);
    chk(error == VEC[i][3][0], "R4", "error flag", error, VEC[i][3]);
    chk(pll_on == VEC[i][4][0], "R7", "pll_on after power-up", pll_on, VEC[i][4]);
    if (VEC[i][4] != 0) begin
      exp_tick = ((lock_at + P_POLL - 1) / P_POLL) * P_POLL;
      chk(on_tcnt == exp_tick, "R3", "lock accepted at tick", on_tcnt, exp_tick);
      chk(tr[I_SB] - tr[I_MB] == SET, "R2", "slave bias delay", tr[I_SB] - tr[I_MB], SET);
      chk(tr[I_PS] - tr[I_SB] >= SET, "R2", "run bit after bias", tr[I_PS] - tr[I_SB], SET);
      chk(tf[I_MR] - tr[I_MR] == 1, "R5", "master reset width", tf[I_MR] - tr[I_MR], 1);
      chk(tr[I_SR] >= tf[I_MR] && tr[I_SR] >= 0, "R5", "slave reset after master", tr[I_SR], tf[I_MR]);
      chk(tf[I_SR] < tr[I_MC] && tf[I_SR] >= 0, "R5", "resets end before clock", tf[I_SR], tr[I_MC]);
      chk(tr[I_SC] > tr[I_MC] && tr[I_MC] >= 0, "R6", "slave clock after master", tr[I_SC], tr[I_MC]);
      chk(m_clk_en && s_clk_en, "R6", "both clocks enabled", {m_clk_en, s_clk_en}, 3);
      chk(tr[I_ON] >= 0 && tr[I_ON] <= tr[I_MR], "R7", "pll_on rises at lock", tr[I_ON], tr[I_MR]);
      if (i == 0) chk(u1_on && u1_mc, "R10", "no-slave instance up", {u1_on, u1_mc}, 3);
      pulse_stop();
      wait_done("R8");
      chk(tf[I_ON] >= 0 && tf[I_ON] < tf[I_MC], "R7", "pll_on falls before gating", tf[I_ON], tf[I_MC]);
      chk(tf[I_MC] < tf[I_PS], "R8", "master gate before run bit", tf[I_MC], tf[I_PS]);
      chk(tf[I_PS] < tf[I_MB], "R8", "run bit before master bias", tf[I_PS], tf[I_MB]);
      chk(tf[I_SC] - tf[I_MB] >= SET, "R8", "slave gate after master settle", tf[I_SC] - tf[I_MB], SET);
      chk(tf[I_SC] < tf[I_SB], "R8", "slave gate before slave bias", tf[I_SC], tf[I_SB]);
      chk(watch == 8'h00, "R8", "all strobes off", watch, 0);
    end else if (VEC[i][3] != 0) begin
      chk(tr[I_MR] < 0 && tr[I_SR] < 0, "R4", "no reset after timeout", tr[I_MR], -1);
      chk(tr[I_MC] < 0 && tr[I_SC] < 0, "R4", "no clock after timeout", tr[I_MC], -1);
      if (glitch_at != 0) chk(tr[I_ON] < 0, "R3", "off-sample lock ignored", tr[I_ON], -1);
      pulse_stop();
      wait_done("R11");
      chk(error == 1'b1, "R11", "error held through power-down", error, 1);
      chk(watch == 8'h00, "R11", "strobes off after failed power-down", watch, 0);
    end else begin
      chk(tr[I_MR] < 0 && tr[I_MC] < 0, "R9", "no reset or clock on abort", tr[I_MC], -1);
      chk(tr[I_ON] < 0, "R9", "pll_on never rose", tr[I_ON], -1);
      chk(tf[I_PS] >= 0 && tf[I_MB] >= 0 && tf[I_SB] >= 0, "R9", "powered down", tf[I_PS], 0);
      chk(watch == 8'h00 && !error, "R9", "idle and no error", watch, 0);
    end
  endtask

  initial begin
    clear_stamps();
    repeat (3) @(negedge clk);
    chk({watch, done, error} == 10'h000, "R1", "outputs low in reset", {watch, done, error}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({watch, done, error} == 10'h000, "R1", "outputs low after reset", {watch, done, error}, 0);
    for (int i = 0; i < NV; i++) run_vec(i);
    repeat (40) @(negedge clk);
    chk(!u1_s_seen, "R10", "slave strobes of no-slave instance", u1_s_seen, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc == 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule